// File: doc/BRIEF.md
# Serial Three-Wire EEPROM Command Front-End

This block is the slave side of a three-wire serial nonvolatile memory built around a byte-wide register array. While chip select is high it samples data-in on each rising edge of the serial clock. It recognises a frame that starts with a leading one bit and carries a two-bit opcode and a seven-bit byte address. It then reads the array out on data-out, gathers page-write bytes in a staging buffer, or marks an erase or fill operation as pending.

Nothing changes in the array while the frame is still open. A modifying command takes effect in the cycle after chip select falls. The block then gives a one-cycle start pulse and an operation code to the separate self-timed programming engine. A write-enable latch gates every command that changes memory. Reads ignore the latch. Any frame whose bit count does not match its command is discarded and has no effect.

Top module: `mw_eeprom_front`

## Requirements
- R1: After reset the write-enable latch is cleared, every array byte reads 0xFF, do_o is 1 and prog_start is 0.
- R2: A frame begins at the first 1 sampled on a rising sk edge while cs is high; zeros before it are ignored. It is followed by a 2-bit opcode and a 7-bit address, MSB first. The opcodes are 10 read, 01 page write and 11 erase. With opcode 00, address bits [6:5] select the command: 11 enable writes, 00 disable writes, 10 erase all, 01 fill all.
- R3: The enable command sets the write-enable latch and the disable command clears it. Each takes effect when cs falls at the end of a frame with exactly 10 bits.
- R4: While the latch is cleared, page write, erase, erase-all and fill-all leave the array unchanged and raise no prog_start.
- R5: Read drives do_o MSB first. Bit 7 appears after the rising edge that samples the last address bit, and each later rising edge presents the next bit. Read works whatever the latch state.
- R6: While cs stays high, a read continues with the next higher address every 8 clocks. The address wraps from 0x7F to 0x00.
- R7: Page write stores each complete 8-bit group at the next address. Only the low 4 address bits count up, wrapping 0xF to 0x0, and bits [6:4] stay fixed. Nothing is stored before cs falls.
- R8: Erase sets the addressed byte to 0xFF. Erase-all sets every byte to 0xFF. Fill-all (exactly one data byte) writes that byte to every location.
- R9: An accepted modifying command gives one prog_start pulse in the cycle after cs falls, with prog_op set to 0 for page write, 1 for erase, 2 for erase-all and 3 for fill-all.
- R10: cs low ends the frame. Clocks sent afterwards without a new start bit leave do_o at 1.
- R11: The following frames are discarded with no change to the array and no prog_start: cs falling inside the opcode or address, extra bits after erase, and a page write ending in a partial byte.
- R12: do_o is 1 whenever no read data is being shifted out, and it returns to 1 within one cycle of cs going low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples sk |
| rst_n | input | 1 | Active-low asynchronous reset (power-up) |
| cs | input | 1 | Chip select, active high |
| sk | input | 1 | Serial clock from the host |
| di | input | 1 | Serial data in |
| do_o | output | 1 | Serial data out, idles at 1 |
| prog_start | output | 1 | One-cycle start pulse to the programming engine |
| prog_op | output | 2 | Operation code qualifying prog_start |

## Verification
The hardest case to reach from the ports is a page write whose pointer passes the top of its 16-byte page while cs stays high. Bytes must land back at the bottom of the same page and must not be stored before cs falls. The stimulus starts a four-byte write two bytes below a page boundary. It confirms that no start pulse appears while cs is still high, then reads the locations back through the continuous-read path. Discarded frames are checked the same way: the byte they could have touched is read back, and the start-pulse counter is confirmed unchanged.

// File: rtl/mw_eeprom_front.sv
module mw_eeprom_front #(
  parameter int AW = 7,
  parameter int DW = 8,
  parameter int PW = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs,
  input  logic       sk,
  input  logic       di,
  output logic       do_o,
  output logic       prog_start,
  output logic [1:0] prog_op
);
  localparam int DEPTH = 1 << AW;
  localparam int PAGE  = 1 << PW;
  localparam int HB    = 2 + AW;
  localparam int HCW   = $clog2(HB);
  localparam int BW    = $clog2(DW);

  typedef enum logic [2:0] {S_IDLE, S_HDR, S_RD, S_WDAT, S_TAIL, S_BAD} st_t;
  typedef enum logic [2:0] {C_READ, C_WRITE, C_ERASE, C_EWEN, C_EWDS, C_ERAL, C_WRAL} cmd_t;

  st_t  st;
  cmd_t cmd;
  logic sk_q, wen;
  logic [HB-2:0]  hdr;
  logic [HCW-1:0] hcnt;
  logic [AW-1:0]  addr, raddr;
  logic [PW-1:0]  ptr;
  logic [DW-1:0]  sh, rd_sh;
  logic [BW-1:0]  bcnt, rcnt;
  logic [1:0]     nb;
  logic [PAGE-1:0] sv;
  logic [DW-1:0]  stage [PAGE];
  logic [DW-1:0]  mem   [DEPTH];

  logic [HB-1:0] full;
  logic sk_rise, wdat_ok;
  assign full    = {hdr, di};
  assign sk_rise = sk & ~sk_q;
  assign wdat_ok = (bcnt == '0) && (nb != 2'd0) && (cmd == C_WRITE || nb == 2'd1);
  assign do_o    = (st == S_RD) ? rd_sh[DW-1] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cmd <= C_READ; sk_q <= 1'b0; wen <= 1'b0;
      hdr <= '0; hcnt <= '0; addr <= '0; raddr <= '0; ptr <= '0;
      sh <= '0; rd_sh <= '0; bcnt <= '0; rcnt <= '0; nb <= '0; sv <= '0;
      prog_start <= 1'b0; prog_op <= 2'd0;
      for (int i = 0; i < PAGE; i++) stage[i] <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else begin
      sk_q <= sk;
      prog_start <= 1'b0;
      if (!cs) begin
        if (st == S_TAIL || (st == S_WDAT && wdat_ok)) begin
          case (cmd)
            C_EWEN: wen <= 1'b1;
            C_EWDS: wen <= 1'b0;
            C_WRITE: if (wen) begin
              for (int i = 0; i < PAGE; i++)
                if (sv[i]) mem[{addr[AW-1:PW], PW'(i)}] <= stage[i];
              prog_start <= 1'b1; prog_op <= 2'd0;
            end
            C_ERASE: if (wen) begin
              mem[addr] <= '1;
              prog_start <= 1'b1; prog_op <= 2'd1;
            end
            C_ERAL: if (wen) begin
              for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
              prog_start <= 1'b1; prog_op <= 2'd2;
            end
            C_WRAL: if (wen) begin
              for (int i = 0; i < DEPTH; i++) mem[i] <= stage[0];
              prog_start <= 1'b1; prog_op <= 2'd3;
            end
            default: ;
          endcase
        end
        st <= S_IDLE;
      end else if (sk_rise) begin
        case (st)
          S_IDLE: if (di) begin
            st <= S_HDR; hcnt <= '0; sv <= '0; nb <= '0; bcnt <= '0;
          end
          S_HDR: begin
            hdr  <= full[HB-2:0];
            hcnt <= hcnt + 1'b1;
            if (hcnt == HCW'(HB - 1)) begin
              addr <= full[AW-1:0];
              ptr  <= full[PW-1:0];
              case (full[HB-1:HB-2])
                2'b10: begin
                  cmd <= C_READ; st <= S_RD; rcnt <= '0;
                  rd_sh <= mem[full[AW-1:0]];
                  raddr <= full[AW-1:0] + 1'b1;
                end
                2'b01: begin cmd <= C_WRITE; st <= S_WDAT; end
                2'b11: begin cmd <= C_ERASE; st <= S_TAIL; end
                default: case (full[AW-1:AW-2])
                  2'b11:   begin cmd <= C_EWEN; st <= S_TAIL; end
                  2'b00:   begin cmd <= C_EWDS; st <= S_TAIL; end
                  2'b10:   begin cmd <= C_ERAL; st <= S_TAIL; end
                  default: begin cmd <= C_WRAL; st <= S_WDAT; ptr <= '0; end
                endcase
              endcase
            end
          end
          S_RD: begin
            if (rcnt == BW'(DW - 1)) begin
              rd_sh <= mem[raddr]; raddr <= raddr + 1'b1; rcnt <= '0;
            end else begin
              rd_sh <= rd_sh << 1; rcnt <= rcnt + 1'b1;
            end
          end
          S_WDAT: begin
            sh   <= {sh[DW-2:0], di};
            bcnt <= bcnt + 1'b1;
            if (bcnt == BW'(DW - 1)) begin
              stage[ptr] <= {sh[DW-2:0], di};
              sv[ptr] <= 1'b1;
              ptr <= ptr + 1'b1;
              nb  <= (nb == 2'd3) ? nb : nb + 1'b1;
            end
          end
          S_TAIL:  st <= S_BAD;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/mw_eeprom_front_chk.sv
module mw_eeprom_front_chk (
  input logic clk,
  input logic rst_n,
  input logic cs,
  input logic do_o,
  input logic prog_start,
  input logic wen
);
  p_do_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !cs |=> do_o);
  p_start_after_cs_r9: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start |-> !$past(cs));
  p_start_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start |=> !prog_start);
  p_gate_by_wen_r4: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start |-> wen);
  p_wen_set_at_cs_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wen) |-> !$past(cs));
  p_wen_clr_at_cs_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wen) |-> !$past(cs));
endmodule

bind mw_eeprom_front mw_eeprom_front_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs(cs), .do_o(do_o),
  .prog_start(prog_start), .wen(wen)
);

// File: tb/mw_eeprom_front_tb.sv
module mw_eeprom_front_tb;
  logic clk = 1'b0, rst_n = 1'b0, cs = 1'b0, sk = 1'b0, di = 1'b0;
  logic do_o, prog_start;
  logic [1:0] prog_op;
  int total = 0, bad = 0, pcount = 0;
  logic [1:0] plast = 2'd0;
  logic [7:0] model [128];
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  mw_eeprom_front u_dut (.clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .di(di),
    .do_o(do_o), .prog_start(prog_start), .prog_op(prog_op));

  always @(posedge clk) if (prog_start) begin pcount++; plast = prog_op; end

  localparam logic [14:0] WVEC [6] = '{
    {7'h00, 8'hA5}, {7'h01, 8'h3C}, {7'h2A, 8'h00},
    {7'h55, 8'hF0}, {7'h7F, 8'h81}, {7'h40, 8'h5A}};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input logic b);
    di = b;
    repeat (2) @(negedge clk);
    sk = 1'b1;
    repeat (3) @(negedge clk);
    sk = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic send(input logic [15:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) tick(v[i]);
  endtask

  task automatic hdr(input logic [1:0] op, input logic [6:0] a);
    cs = 1'b1;
    @(negedge clk);
    tick(1'b1);
    send({14'd0, op}, 2);
    send({9'd0, a}, 7);
  endtask

  task automatic cs_off;
    cs = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic rd(input string req, input logic [6:0] a, input int n);
    logic [7:0] b;
    hdr(2'b10, a);
    for (int k = 0; k < n; k++) begin
      if (k > 0) tick(1'b0);
      b[7] = do_o;
      for (int j = 6; j >= 0; j--) begin tick(1'b0); b[j] = do_o; end
      check(req, {24'd0, b}, {24'd0, model[7'(a + k)]});
    end
    cs_off();
  endtask

  task automatic special(input logic [1:0] sel);
    hdr(2'b00, {sel, 5'd0});
    cs_off();
  endtask

  initial begin
    #900000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int pc;
    for (int i = 0; i < 128; i++) model[i] = 8'hFF;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 do idle", {31'd0, do_o}, 32'd1);
    check("R1 start low", {31'd0, prog_start}, 32'd0);
    rd("R1 erased", 7'h05, 1);

    // R4: write with latch cleared
    hdr(2'b01, 7'h03); send(16'h12, 8); cs_off();
    check("R4 no start", pcount, 0);
    rd("R4 unchanged", 7'h03, 1);

    special(2'b11);  // R3 enable
    foreach (WVEC[k]) begin
      pc = pcount;
      hdr(2'b01, WVEC[k][14:8]); send({8'd0, WVEC[k][7:0]}, 8); cs_off();
      model[WVEC[k][14:8]] = WVEC[k][7:0];
      check("R9 write pulse", pcount, pc + 1);
      check("R9 write op", {30'd0, plast}, 32'd0);
      rd("R7 single byte", WVEC[k][14:8], 1);
    end

    // R7 page wrap inside page 1
    pc = pcount;
    hdr(2'b01, 7'h1E);
    for (int k = 0; k < 4; k++) send({8'd0, 8'hC0 + 8'(k)}, 8);
    check("R7 no store before cs low", pcount, pc);
    cs_off();
    model[7'h1E] = 8'hC0; model[7'h1F] = 8'hC1; model[7'h10] = 8'hC2; model[7'h11] = 8'hC3;
    check("R7 page pulse", pcount, pc + 1);
    rd("R7 wrap low", 7'h10, 2);
    rd("R7 high", 7'h1E, 2);
    rd("R7 page 2 untouched", 7'h20, 1);

    rd("R6 wrap read", 7'h7E, 4);

    hdr(2'b11, 7'h10); cs_off();
    model[7'h10] = 8'hFF;
    check("R9 erase op", {30'd0, plast}, 32'd1);
    rd("R8 erase", 7'h0F, 3);

    // R11 discarded frames
    pc = pcount;
    hdr(2'b11, 7'h00); tick(1'b0); cs_off();
    check("R11 erase extra bit", pcount, pc);
    rd("R11 erase extra bit", 7'h00, 1);
    hdr(2'b01, 7'h01); send(16'h33, 8); send(16'h3, 4); cs_off();
    check("R11 partial byte", pcount, pc);
    rd("R11 partial byte", 7'h01, 2);
    cs = 1'b1; tick(1'b1); send(16'h1, 2); send(16'h2, 3); cs_off();
    check("R11 cs drop in address", pcount, pc);

    // R2 leading zeros before start bit
    cs = 1'b1; tick(1'b0); tick(1'b0);
    hdr(2'b01, 7'h40); send(16'h77, 8); cs_off();
    model[7'h40] = 8'h77;
    check("R2 leading zeros", pcount, pc + 1);
    rd("R2 leading zeros", 7'h40, 1);

    // R10 after cs low no frame without start bit
    cs = 1'b1;
    for (int k = 0; k < 3; k++) begin tick(1'b0); check("R10 no output", {31'd0, do_o}, 32'd1); end
    cs_off();

    hdr(2'b00, 7'h20); send(16'h5A, 8); cs_off();
    for (int i = 0; i < 128; i++) model[i] = 8'h5A;
    check("R9 fill op", {30'd0, plast}, 32'd3);
    rd("R8 fill all", 7'h7F, 3);

    special(2'b10);
    for (int i = 0; i < 128; i++) model[i] = 8'hFF;
    check("R9 erase-all op", {30'd0, plast}, 32'd2);
    rd("R8 erase all", 7'h33, 2);

    hdr(2'b01, 7'h08); send(16'h99, 8); cs_off();
    model[7'h08] = 8'h99;
    special(2'b00);  // R3 disable
    pc = pcount;
    hdr(2'b11, 7'h08); cs_off();
    special(2'b10);
    check("R4 gated after disable", pcount, pc);
    rd("R5 read with latch off", 7'h08, 1);
    check("R12 idle after read", {31'd0, do_o}, 32'd1);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule